// File: doc/BRIEF.md
# Shared Cache Set Balance Controller

This block decides, for each core, which of several alternate set-index functions the cache mapper should apply to that core's addresses. It keeps a small signed counter per core. The counter moves up when the core touches a new stack-distance position in a set in the upper half of the shared region. It moves down when the set is in the lower half. The counters of all cores are added together, and the absolute value of that sum is the measure of imbalance across the cache sets.

When an evaluate strobe arrives and the imbalance is larger than a programmable threshold, the block starts a search. On each step it advances one core's index function to the next one. The cores are taken in a fixed round-robin order. Every change clears the counters, so the next measurement epoch starts from zero. At each later strobe the new imbalance is compared with the threshold and with the best combination found so far. The search ends in one of two ways. If balance is reached, the block keeps the combination in use at that point. If the step budget runs out, it restores the combination that gave the smallest imbalance.

Top module: `set_bal_ctrl`

## Requirements
- R1: A valid access with the first-touch flag and the shared flag set, whose set index has its most significant bit at 1, raises the counter of the core named by `acc_core_i` by one.
- R2: The same kind of access with the set index most significant bit at 0 lowers that core's counter by one.
- R3: Counters saturate at +2^(CNT_W-1)-1 and -2^(CNT_W-1); they never wrap.
- R4: An access with the shared flag or the first-touch flag at 0 leaves every counter unchanged.
- R5: On an evaluate strobe in idle, if the absolute sum of all core counters is at most `thresh_i`, no selection changes.
- R6: On an evaluate strobe in idle with the absolute sum above the threshold and `limit_i` nonzero, a search starts. Each search step adds one, modulo 2^FN_W, to the function code of the core under a round-robin pointer. The pointer starts at core 0 after reset, advances one core per step, and is kept between searches. `fn_sel_o` holds core k's code at bits [k*FN_W +: FN_W].
- R7: During a search, an evaluate strobe that finds the absolute sum within the threshold ends the search and keeps the current selection.
- R8: When `limit_i` steps have been tried and the next strobe is still out of balance, the selection is set to the combination with the smallest absolute sum measured in this search. The starting combination counts, and the earliest one wins a tie. The search then ends.
- R9: Every evaluate strobe that can change the selection clears all counters. An access in that same cycle is dropped.
- R10: With `limit_i` at 0 the selection never changes.
- R11: After reset every function code is 0.
- R12: The selection changes only in a cycle in which `eval_i` is high.

Parameter defaults are NUM_CORES=4, SET_W=10, CNT_W=8, FN_W=2 and LIM_W=4. The width SUM_W is CNT_W + clog2(NUM_CORES) + 1, which is 11 by default.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| acc_valid_i | input | 1 | Access event present |
| acc_core_i | input | clog2(NUM_CORES) | Issuing core |
| acc_set_i | input | SET_W | Set index of the access |
| acc_first_i | input | 1 | First touch of a stack-distance position |
| acc_shared_i | input | 1 | Access falls in the shared region |
| eval_i | input | 1 | Evaluate strobe, one cycle |
| thresh_i | input | SUM_W | Largest absolute sum treated as balanced |
| limit_i | input | LIM_W | Search step budget |
| fn_sel_o | output | NUM_CORES*FN_W | Per-core index function codes |

## Verification
The assertions assume that `eval_i` is a single-cycle pulse. They also assume that `thresh_i` and `limit_i` stay constant while a search is running, so that step counting and best tracking refer to one budget. The stimulus applies a reset before each vector. It changes the threshold and the limit only while the block is idle, and it drives `eval_i` high for exactly one cycle, never in the same cycle as an access. The one exception is the saturation test, which pushes a counter far past its limit with a long run of accesses.

// File: rtl/set_bal_pkg.sv
package set_bal_pkg;
  typedef enum logic {ST_IDLE, ST_SEARCH} srch_st_e;
endpackage

// File: rtl/sb_core_cnt.sv
module sb_core_cnt #(
  parameter int CNT_W = 8
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    clr_i,
  input  logic                    inc_i,
  input  logic                    dec_i,
  output logic signed [CNT_W-1:0] cnt_o
);
  localparam logic signed [CNT_W-1:0] MaxV = {1'b0, {(CNT_W-1){1'b1}}};
  localparam logic signed [CNT_W-1:0] MinV = {1'b1, {(CNT_W-1){1'b0}}};

  logic signed [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                     cnt_q <= '0;
    else if (clr_i)                  cnt_q <= '0;
    else if (inc_i && cnt_q != MaxV) cnt_q <= cnt_q + 1'b1;
    else if (dec_i && cnt_q != MinV) cnt_q <= cnt_q - 1'b1;
  end

  assign cnt_o = cnt_q;

  // R3
  sat_hi_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cnt_q == MaxV && inc_i && !clr_i) |=> cnt_q == MaxV);
  // R1
  inc_step_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (inc_i && !clr_i && cnt_q != MaxV) |=> cnt_q == $past(cnt_q) + 1'b1);
  // R9
  clr_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_i |=> cnt_q == '0);
endmodule

// File: rtl/sb_sum_abs.sv
module sb_sum_abs #(
  parameter int NUM_CORES = 4,
  parameter int CNT_W     = 8,
  parameter int SUM_W     = 11
) (
  input  logic [NUM_CORES-1:0][CNT_W-1:0] cnt_i,
  output logic [SUM_W-1:0]                abs_o
);
  logic [SUM_W-1:0] acc;

  always_comb begin
    acc = '0;
    for (int i = 0; i < NUM_CORES; i++)
      acc = acc + {{(SUM_W-CNT_W){cnt_i[i][CNT_W-1]}}, cnt_i[i]};
    abs_o = acc[SUM_W-1] ? (~acc + 1'b1) : acc;
  end
endmodule

// File: rtl/sb_search.sv
module sb_search
  import set_bal_pkg::*;
#(
  parameter int NUM_CORES = 4,
  parameter int FN_W      = 2,
  parameter int SUM_W     = 11,
  parameter int LIM_W     = 4,
  localparam int PTR_W    = $clog2(NUM_CORES)
) (
  input  logic                               clk_i,
  input  logic                               rst_ni,
  input  logic                               eval_i,
  input  logic [SUM_W-1:0]                   abs_i,
  input  logic [SUM_W-1:0]                   thresh_i,
  input  logic [LIM_W-1:0]                   limit_i,
  output logic [NUM_CORES-1:0][FN_W-1:0]     sel_o,
  output logic                               clr_o
);
  srch_st_e                       state_q, state_n;
  logic [NUM_CORES-1:0][FN_W-1:0] sel_q, sel_n, best_sel_q, best_sel_n;
  logic [SUM_W-1:0]               best_abs_q, best_abs_n;
  logic [LIM_W-1:0]               tries_q, tries_n;
  logic [PTR_W-1:0]               ptr_q, ptr_n;
  logic                           bal, better, do_step;

  assign bal    = abs_i <= thresh_i;
  assign better = abs_i < best_abs_q;

  always_comb begin
    state_n    = state_q;
    sel_n      = sel_q;
    best_sel_n = best_sel_q;
    best_abs_n = best_abs_q;
    tries_n    = tries_q;
    ptr_n      = ptr_q;
    clr_o      = 1'b0;
    do_step    = 1'b0;
    if (eval_i) begin
      if (state_q == ST_IDLE) begin
        if (!bal && limit_i != '0) begin
          best_abs_n = abs_i;
          best_sel_n = sel_q;
          tries_n    = '0;
          do_step    = 1'b1;
          state_n    = ST_SEARCH;
        end
      end else if (bal) begin
        state_n = ST_IDLE;
      end else begin
        if (better) begin
          best_abs_n = abs_i;
          best_sel_n = sel_q;
        end
        if (tries_q >= limit_i) begin
          sel_n   = better ? sel_q : best_sel_q;
          clr_o   = 1'b1;
          state_n = ST_IDLE;
        end else begin
          do_step = 1'b1;
        end
      end
    end
    if (do_step) begin
      sel_n[ptr_q] = sel_q[ptr_q] + 1'b1;
      ptr_n        = (ptr_q == PTR_W'(NUM_CORES-1)) ? '0 : ptr_q + 1'b1;
      tries_n      = tries_n + 1'b1;
      clr_o        = 1'b1;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q    <= ST_IDLE;
      sel_q      <= '0;
      best_sel_q <= '0;
      best_abs_q <= '0;
      tries_q    <= '0;
      ptr_q      <= '0;
    end else begin
      state_q    <= state_n;
      sel_q      <= sel_n;
      best_sel_q <= best_sel_n;
      best_abs_q <= best_abs_n;
      tries_q    <= tries_n;
      ptr_q      <= ptr_n;
    end
  end

  assign sel_o = sel_q;

  // R12
  sel_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !eval_i |=> $stable(sel_q));
  // R10
  no_lim_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_IDLE && limit_i == '0) |=> state_q == ST_IDLE);
  // R5
  bal_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_IDLE && eval_i && abs_i <= thresh_i) |=> $stable(sel_q));
endmodule

// File: rtl/set_bal_ctrl.sv
module set_bal_ctrl #(
  parameter int NUM_CORES = 4,
  parameter int SET_W     = 10,
  parameter int CNT_W     = 8,
  parameter int FN_W      = 2,
  parameter int LIM_W     = 4,
  localparam int CORE_W   = $clog2(NUM_CORES),
  localparam int SUM_W    = CNT_W + $clog2(NUM_CORES) + 1
) (
  input  logic                      clk_i,
  input  logic                      rst_ni,
  input  logic                      acc_valid_i,
  input  logic [CORE_W-1:0]         acc_core_i,
  input  logic [SET_W-1:0]          acc_set_i,
  input  logic                      acc_first_i,
  input  logic                      acc_shared_i,
  input  logic                      eval_i,
  input  logic [SUM_W-1:0]          thresh_i,
  input  logic [LIM_W-1:0]          limit_i,
  output logic [NUM_CORES*FN_W-1:0] fn_sel_o
);
  logic [NUM_CORES-1:0][CNT_W-1:0] cnt;
  logic [NUM_CORES-1:0][FN_W-1:0]  sel;
  logic [SUM_W-1:0]                abs_sum;
  logic                            clr;
  logic                            counted;

  assign counted = acc_valid_i && acc_first_i && acc_shared_i;

  for (genvar g = 0; g < NUM_CORES; g++) begin : g_core
    logic hit;
    assign hit = counted && (acc_core_i == CORE_W'(g));
    sb_core_cnt #(.CNT_W(CNT_W)) u_cnt (
      .clk_i (clk_i),
      .rst_ni(rst_ni),
      .clr_i (clr),
      .inc_i (hit &&  acc_set_i[SET_W-1]),
      .dec_i (hit && !acc_set_i[SET_W-1]),
      .cnt_o (cnt[g])
    );
  end

  sb_sum_abs #(.NUM_CORES(NUM_CORES), .CNT_W(CNT_W), .SUM_W(SUM_W)) u_sum (
    .cnt_i(cnt),
    .abs_o(abs_sum)
  );

  sb_search #(.NUM_CORES(NUM_CORES), .FN_W(FN_W), .SUM_W(SUM_W), .LIM_W(LIM_W)) u_srch (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .eval_i  (eval_i),
    .abs_i   (abs_sum),
    .thresh_i(thresh_i),
    .limit_i (limit_i),
    .sel_o   (sel),
    .clr_o   (clr)
  );

  assign fn_sel_o = sel;

  // R4
  ignore_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!counted && !clr) |=> $stable(cnt));
endmodule

// File: tb/tb_set_bal_ctrl.sv
`timescale 1ns/1ps
module tb_set_bal_ctrl;
  localparam int SUM_W = 11;

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        acc_valid_i = 1'b0;
  logic [1:0]  acc_core_i = '0;
  logic [9:0]  acc_set_i = '0;
  logic        acc_first_i = 1'b0;
  logic        acc_shared_i = 1'b0;
  logic        eval_i = 1'b0;
  logic [SUM_W-1:0] thresh_i = '0;
  logic [3:0]  limit_i = '0;
  logic [7:0]  fn_sel_o;

  int total = 0;
  int bad = 0;
  bit done = 1'b0;

  always #2.5 clk_i = ~clk_i;

  set_bal_ctrl dut (.*);

  typedef struct packed {
    logic [7:0] up0;
    logic [7:0] dn0;
    logic [7:0] dn1;
    logic [7:0] thr;
    logic [3:0] lim;
    logic [7:0] exp_sel;
  } vec_t;

  localparam vec_t VEC [6] = '{
    '{8'd10, 8'd10, 8'd0, 8'd0, 4'd4, 8'h00}, // R5 self-cancelling
    '{8'd5,  8'd0,  8'd0, 8'd4, 4'd4, 8'h01}, // R1 R6 above threshold
    '{8'd0,  8'd3,  8'd0, 8'd3, 4'd4, 8'h00}, // R2 R5 at threshold
    '{8'd0,  8'd6,  8'd0, 8'd3, 4'd4, 8'h01}, // R2 negative imbalance
    '{8'd4,  8'd0,  8'd4, 8'd0, 4'd4, 8'h00}, // R5 summed across cores
    '{8'd7,  8'd0,  8'd0, 8'd0, 4'd0, 8'h00}  // R10 zero limit
  };

  task automatic check(input bit ok, input string req, input logic [7:0] act, input logic [7:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk_i);
    rst_ni = 1'b0;
    @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);
  endtask

  task automatic acc(input int core, input bit upper, input int n,
                     input bit shared = 1'b1, input bit first = 1'b1);
    for (int i = 0; i < n; i++) begin
      acc_valid_i  = 1'b1;
      acc_core_i   = 2'(core);
      acc_set_i    = upper ? 10'h2A5 : 10'h0A5;
      acc_shared_i = shared;
      acc_first_i  = first;
      @(negedge clk_i);
    end
    acc_valid_i = 1'b0;
  endtask

  task automatic evaluate();
    eval_i = 1'b1;
    @(negedge clk_i);
    eval_i = 1'b0;
    @(negedge clk_i);
  endtask

  initial begin
    #(200000 * 5);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog expired");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    do_reset();
    check(fn_sel_o == 8'h00, "R11", fn_sel_o, 8'h00);

    foreach (VEC[i]) begin
      do_reset();
      thresh_i = SUM_W'(VEC[i].thr);
      limit_i  = VEC[i].lim;
      acc(0, 1'b1, int'(VEC[i].up0));
      acc(0, 1'b0, int'(VEC[i].dn0));
      acc(1, 1'b0, int'(VEC[i].dn1));
      evaluate();
      check(fn_sel_o == VEC[i].exp_sel, $sformatf("R5/R6 vector %0d", i), fn_sel_o, VEC[i].exp_sel);
    end

    // R3 saturation: 200 up then 127 down lands at zero only if capped at 127
    do_reset();
    thresh_i = '0; limit_i = 4'd4;
    acc(0, 1'b1, 200);
    acc(0, 1'b0, 127);
    evaluate();
    check(fn_sel_o == 8'h00, "R3", fn_sel_o, 8'h00);

    // R4 non-shared and non-first accesses ignored
    do_reset();
    acc(2, 1'b1, 10, 1'b0, 1'b1);
    acc(2, 1'b1, 10, 1'b1, 1'b0);
    evaluate();
    check(fn_sel_o == 8'h00, "R4", fn_sel_o, 8'h00);

    // R6 R8 R9 R12 search with limit 3
    do_reset();
    thresh_i = '0; limit_i = 4'd3;
    acc(0, 1'b1, 10);
    evaluate();
    check(fn_sel_o == 8'h01, "R6 first step", fn_sel_o, 8'h01);
    acc(0, 1'b1, 6);
    check(fn_sel_o == 8'h01, "R12", fn_sel_o, 8'h01);
    evaluate();
    check(fn_sel_o == 8'h05, "R6 round robin", fn_sel_o, 8'h05);
    acc(0, 1'b1, 8);
    evaluate();
    check(fn_sel_o == 8'h15, "R6 third core", fn_sel_o, 8'h15);
    acc(0, 1'b1, 9);
    evaluate();
    check(fn_sel_o == 8'h01, "R8 R9 best restored", fn_sel_o, 8'h01);
    evaluate();
    check(fn_sel_o == 8'h01, "R9 counters cleared", fn_sel_o, 8'h01);

    // R7 balance reached mid-search, pointer kept for next search
    do_reset();
    thresh_i = SUM_W'(1); limit_i = 4'd4;
    acc(0, 1'b1, 5);
    evaluate();
    check(fn_sel_o == 8'h01, "R7 start", fn_sel_o, 8'h01);
    acc(0, 1'b1, 1);
    evaluate();
    check(fn_sel_o == 8'h01, "R7 stop kept", fn_sel_o, 8'h01);
    acc(0, 1'b1, 5);
    evaluate();
    check(fn_sel_o == 8'h05, "R7 R6 pointer kept", fn_sel_o, 8'h05);

    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule